// File: doc/BRIEF.md
# Serial Program-and-Verify Sequencer

This block runs on the host side of a two-wire serial programming link: a clock line that only the host drives and a bidirectional data line. When started, it takes words one by one from an image memory and writes each into the target. For every word it sends a load-data command followed by its data frame. It then sends a begin-programming command and waits out the programming time. After that it sends a read command, captures the returned frame, and compares the returned word with the image. It moves the target to the next address only when the comparison succeeds.

The run ends in one of two ways. Either every word has been written and verified, or the first mismatch stops it and the index of the failing word is reported. The serial clock half-period, the gap between frames and the programming wait are all set by parameters, counted in system-clock cycles.

The controller is a single state machine with these states:
- `S_IDLE`: after reset.
- `S_LDCMD`: sends the load-data command.
- `S_LDDAT`: sends the data frame for that word.
- `S_PGCMD`: sends the begin-programming command.
- `S_RDCMD`: sends the read command.
- `S_RDDAT`: receives the read frame.
- `S_CMP`: compares the returned word with the image.
- `S_INCCMD`: sends the increment command.
- `S_WAIT`: waits on the delay timer and then moves to a stored return state.
- `S_DONE`: the run finished without a mismatch.
- `S_FAIL`: the run stopped on a mismatch.

The transitions are:
- Each send state launches its frame once. When the frame finishes it enters `S_WAIT`, which returns to the next step of the word sequence.
- After `S_PGCMD`, `S_WAIT` runs for the programming wait. After every other frame it runs for the gap.
- `S_RDDAT` goes straight to `S_CMP`.
- `S_CMP` goes to `S_FAIL` on a mismatch, to `S_DONE` after the last word, and otherwise to `S_WAIT` with `S_INCCMD` as the return state.
- `S_IDLE`, `S_DONE` and `S_FAIL` accept start. They go to `S_LDCMD`, or to `S_DONE` when the word count is zero.

Top module: `prog_verify_seq`

## Requirements
- R1: After reset, `sclk` is low, `sdata_out` is 0, `sdata_oe` is 1, and both `done` and `error` are 0.
- R2: A command is six `sclk` pulses carrying a 6-bit code, lsb first. The codes are: load data 0x02, read data 0x04, increment 0x06, begin programming 0x08. Each bit appears on `sdata_out` at the rising edge of `sclk` and holds until the next rising edge. `sclk` stays high for CLK_HALF cycles and low for CLK_HALF cycles.
- R3: A data frame is 16 `sclk` pulses, lsb first. It carries a 0 start bit, then the 14 data bits, then a 0 stop bit.
- R4: Each word goes through this order: load command, load frame with the image word, begin programming, read command, read frame. An increment command follows only when more words remain; none is sent after the last word.
- R5: Between the last falling `sclk` edge of any frame that is not begin programming and the first rising edge of the next frame, at least GAP_CYC system cycles pass.
- R6: After the begin-programming command, at least PROG_CYC system cycles pass before the next rising `sclk` edge.
- R7: `sdata_oe` is 0 during the read frame and during the gap that comes before it. In that frame, bits 1 to 14 (counting the start bit as bit 0) are taken as the returned word. `sdata_oe` is 1 for every frame the host sends.
- R8: When every word verifies, `done` rises with `error` at 0. Both hold until the next start, and no `sclk` pulse occurs while `done` is high.
- R9: On the first mismatch, no further frame is sent. `done` and `error` both go to 1, and `err_addr` holds the index of the failing word.
- R10: A start with `count` equal to 0 sets `done` with `error` at 0 and produces no `sclk` pulse.
- R11: `start` and `count` are ignored while a run is in progress. The word count is taken at the start.
- R12: During a run, `img_addr` carries the index of the current word, starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when the block is not busy |
| count | input | ADDR_W+1 | Number of words to program |
| img_addr | output | ADDR_W | Image memory read address |
| img_data | input | 14 | Image word at `img_addr` (combinational read) |
| sclk | output | 1 | Serial clock to the target |
| sdata_out | output | 1 | Serial data driven toward the target |
| sdata_oe | output | 1 | High while the host drives the data line |
| sdata_in | input | 1 | Serial data sampled from the target |
| done | output | 1 | Run finished |
| error | output | 1 | Run stopped on a verify mismatch |
| err_addr | output | ADDR_W | Index of the failing word |

## Verification
The bench builds the block with ADDR_W=4, CLK_HALF=2, GAP_CYC=5 and PROG_CYC=40. With these values each word takes a few hundred cycles, which makes two sweeps affordable:
- Every word count from 0 to 8 is run against a behavioural target that checks command order, frame shape, line direction and every gap.
- For a six-word run, a single-bit fault is injected at each address in turn, which exercises both the failure exit and `err_addr`.

// File: rtl/pv_pkg.sv
package pv_pkg;

    localparam int DATA_W  = 14;
    localparam int FRAME_W = 16;
    localparam int CMD_W   = 6;

    localparam logic [CMD_W-1:0] CMD_LOAD = 6'h02;
    localparam logic [CMD_W-1:0] CMD_READ = 6'h04;
    localparam logic [CMD_W-1:0] CMD_INC  = 6'h06;
    localparam logic [CMD_W-1:0] CMD_PROG = 6'h08;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LDCMD,
        S_LDDAT,
        S_PGCMD,
        S_RDCMD,
        S_RDDAT,
        S_CMP,
        S_INCCMD,
        S_WAIT,
        S_DONE,
        S_FAIL
    } pv_state_e;

endpackage

// File: rtl/pv_shift.sv
module pv_shift #(
    parameter int HALF_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [4:0]  nbits,
    input  logic [15:0] tx,
    input  logic        sdi,
    output logic        busy,
    output logic        fin,
    output logic        sclk,
    output logic        sdo,
    output logic [13:0] rx
);

    localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [PW-1:0] PH_END = PW'(HALF_CYC - 1);

    logic [PW-1:0] ph;
    logic [4:0]    bc;
    logic [4:0]    nb;
    logic [15:0]   txr;
    logic          hi;

    assign sclk = hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            fin  <= 1'b0;
            hi   <= 1'b0;
            ph   <= '0;
            bc   <= '0;
            nb   <= '0;
            txr  <= '0;
            sdo  <= 1'b0;
            rx   <= '0;
        end else begin
            fin <= 1'b0;
            if (go && !busy) begin
                busy <= 1'b1;
                hi   <= 1'b1;
                ph   <= '0;
                bc   <= '0;
                nb   <= nbits;
                txr  <= tx;
                sdo  <= tx[0];
                rx   <= '0;
            end else if (busy) begin
                if (ph == PH_END) begin
                    ph <= '0;
                    if (hi) begin
                        hi <= 1'b0;
                        if (bc >= 5'd1 && bc <= 5'd14) begin
                            rx[4'(bc - 5'd1)] <= sdi;
                        end
                    end else if (bc == nb - 5'd1) begin
                        busy <= 1'b0;
                        fin  <= 1'b1;
                    end else begin
                        bc  <= bc + 5'd1;
                        hi  <= 1'b1;
                        sdo <= txr[4'(bc + 5'd1)];
                    end
                end else begin
                    ph <= ph + PW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pv_delay.sv
module pv_delay #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/prog_verify_seq.sv
module prog_verify_seq
    import pv_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int CLK_HALF = 25,
    parameter int GAP_CYC  = 60,
    parameter int PROG_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   count,
    output logic [ADDR_W-1:0] img_addr,
    input  logic [13:0]       img_data,
    output logic              sclk,
    output logic              sdata_out,
    output logic              sdata_oe,
    input  logic              sdata_in,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] err_addr
);

    localparam int IW    = ADDR_W + 1;
    localparam int MAXD  = (PROG_CYC > GAP_CYC) ? PROG_CYC : GAP_CYC;
    localparam int TW    = $clog2(MAXD + 1);
    localparam logic [TW-1:0] GAP_LEN  = TW'(GAP_CYC);
    localparam logic [TW-1:0] PROG_LEN = TW'(PROG_CYC);

    pv_state_e state, state_n;
    pv_state_e ret, ret_n;

    logic          armed, armed_n;
    logic [IW-1:0] idx, idx_n;
    logic [IW-1:0] cnt, cnt_n;
    logic          done_n, err_n;
    logic [ADDR_W-1:0] eaddr_n;

    logic          sh_go, sh_busy, sh_fin;
    logic [4:0]    sh_nbits;
    logic [15:0]   sh_tx;
    logic [13:0]   sh_rx;
    logic          t_load, t_exp;
    logic [TW-1:0] t_len;

    pv_shift #(.HALF_CYC(CLK_HALF)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (sh_go),
        .nbits (sh_nbits),
        .tx    (sh_tx),
        .sdi   (sdata_in),
        .busy  (sh_busy),
        .fin   (sh_fin),
        .sclk  (sclk),
        .sdo   (sdata_out),
        .rx    (sh_rx)
    );

    pv_delay #(.CNT_W(TW)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .len     (t_len),
        .expired (t_exp)
    );

    assign img_addr = idx[ADDR_W-1:0];
    assign sdata_oe = !((state == S_RDDAT) || (state == S_WAIT && ret == S_RDDAT));

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ret      <= S_IDLE;
            armed    <= 1'b0;
            idx      <= '0;
            cnt      <= '0;
            done     <= 1'b0;
            error    <= 1'b0;
            err_addr <= '0;
        end else begin
            state    <= state_n;
            ret      <= ret_n;
            armed    <= armed_n;
            idx      <= idx_n;
            cnt      <= cnt_n;
            done     <= done_n;
            error    <= err_n;
            err_addr <= eaddr_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n  = state;
        ret_n    = ret;
        armed_n  = armed;
        idx_n    = idx;
        cnt_n    = cnt;
        done_n   = done;
        err_n    = error;
        eaddr_n  = err_addr;
        sh_go    = 1'b0;
        sh_nbits = 5'd6;
        sh_tx    = '0;
        t_load   = 1'b0;
        t_len    = GAP_LEN;

        unique case (state)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) begin
                    cnt_n   = count;
                    idx_n   = '0;
                    err_n   = 1'b0;
                    armed_n = 1'b0;
                    if (count == '0) begin
                        done_n  = 1'b1;
                        state_n = S_DONE;
                    end else begin
                        done_n  = 1'b0;
                        state_n = S_LDCMD;
                    end
                end
            end
            S_LDCMD, S_LDDAT, S_PGCMD, S_RDCMD, S_INCCMD: begin
                unique case (state)
                    S_LDCMD:  sh_tx = {10'd0, CMD_LOAD};
                    S_LDDAT:  sh_tx = {1'b0, img_data, 1'b0};
                    S_PGCMD:  sh_tx = {10'd0, CMD_PROG};
                    S_RDCMD:  sh_tx = {10'd0, CMD_READ};
                    default:  sh_tx = {10'd0, CMD_INC};
                endcase
                sh_nbits = (state == S_LDDAT) ? 5'd16 : 5'd6;
                if (!armed) begin
                    sh_go   = 1'b1;
                    armed_n = 1'b1;
                end else if (sh_fin) begin
                    armed_n = 1'b0;
                    t_load  = 1'b1;
                    state_n = S_WAIT;
                    unique case (state)
                        S_LDCMD: ret_n = S_LDDAT;
                        S_LDDAT: ret_n = S_PGCMD;
                        S_PGCMD: begin
                            ret_n = S_RDCMD;
                            t_len = PROG_LEN;
                        end
                        S_RDCMD: ret_n = S_RDDAT;
                        default: begin
                            ret_n = S_LDCMD;
                            idx_n = idx + IW'(1);
                        end
                    endcase
                end
            end
            S_RDDAT: begin
                sh_nbits = 5'd16;
                if (!armed) begin
                    sh_go   = 1'b1;
                    armed_n = 1'b1;
                end else if (sh_fin) begin
                    armed_n = 1'b0;
                    state_n = S_CMP;
                end
            end
            S_CMP: begin
                if (sh_rx != img_data) begin
                    err_n   = 1'b1;
                    done_n  = 1'b1;
                    eaddr_n = idx[ADDR_W-1:0];
                    state_n = S_FAIL;
                end else if (idx + IW'(1) == cnt) begin
                    done_n  = 1'b1;
                    state_n = S_DONE;
                end else begin
                    t_load  = 1'b1;
                    ret_n   = S_INCCMD;
                    state_n = S_WAIT;
                end
            end
            S_WAIT: begin
                if (t_exp && !sh_busy) begin
                    state_n = ret;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

endmodule

// File: rtl/pv_seq_chk.sv
module pv_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic sdata_out,
    input logic sdata_oe,
    input logic done,
    input logic error
);

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);  // R9

    AST_DATA_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && $past(!sclk)) |-> $stable(sdata_out));  // R2

    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sclk);  // R8

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);  // R8

    AST_RELEASE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !done);  // R7

endmodule

bind prog_verify_seq pv_seq_chk u_pv_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sclk      (sclk),
    .sdata_out (sdata_out),
    .sdata_oe  (sdata_oe),
    .done      (done),
    .error     (error)
);

// File: tb/prog_verify_seq_bench.sv
module prog_verify_seq_bench;

    localparam int AW    = 4;
    localparam int HALF  = 2;
    localparam int GAP   = 5;
    localparam int PROG  = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW:0]   count = '0;
    logic [AW-1:0] img_addr;
    logic [13:0]   img_data;
    logic          sclk, sdata_out, sdata_oe, tdata, done, error;
    logic [AW-1:0] err_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int seed     = 0;
    longint cyc  = 0;

    always #4 clk = ~clk;

    function automatic logic [13:0] img_f(input int a, input int s);
        return 14'((a * 1337 + s * 4099) ^ (a << 7) ^ (s << 11));
    endfunction

    assign img_data = img_f(int'(img_addr), seed);

    prog_verify_seq #(
        .ADDR_W(AW), .CLK_HALF(HALF), .GAP_CYC(GAP), .PROG_CYC(PROG)
    ) u_prog_verify_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .count(count),
        .img_addr(img_addr), .img_data(img_data),
        .sclk(sclk), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
        .sdata_in(tdata), .done(done), .error(error), .err_addr(err_addr)
    );

    // behavioural target
    logic [13:0] mem [16];
    logic [15:0] msh, rdw;
    logic [13:0] latch;
    int mmode, mbit, pc, rises, nprog, frames;
    int bad_order, bad_gap, bad_pw, bad_oe, bad_frame;
    int inj_addr, inj_bit;
    logic [5:0] expcmd;
    bit last_prog;
    longint last_fall;

    task automatic model_clear();
        for (int i = 0; i < 16; i++) mem[i] = '0;
        mmode = 0; mbit = 0; pc = 0; rises = 0; nprog = 0; frames = 0;
        bad_order = 0; bad_gap = 0; bad_pw = 0; bad_oe = 0; bad_frame = 0;
        expcmd = 6'h02; last_prog = 0; last_fall = 0; tdata = 1'b0;
        inj_addr = -1; inj_bit = 0; msh = '0; rdw = '0; latch = '0;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge sclk) begin
        rises++;
        if (mbit == 0) begin
            if (frames > 0) begin
                if (last_prog && (cyc - last_fall) < PROG) bad_pw++;
                if (!last_prog && (cyc - last_fall) < GAP) bad_gap++;
            end
            frames++;
        end
        if (mmode == 2) begin
            tdata = rdw[mbit];
            if (sdata_oe) bad_oe++;
        end else if (!sdata_oe) bad_oe++;
    end

    always @(negedge sclk) begin
        last_fall = cyc;
        if (mmode == 0) begin
            msh[mbit] = sdata_out;
            mbit++;
            if (mbit == 6) begin
                mbit = 0;
                if (msh[5:0] != expcmd) bad_order++;
                last_prog = (msh[5:0] == 6'h08);
                case (msh[5:0])
                    6'h02: begin mmode = 1; expcmd = 6'h08; end
                    6'h08: begin
                        mem[pc] = latch ^ ((pc == inj_addr) ? 14'(1 << inj_bit) : 14'd0);
                        nprog++;
                        expcmd = 6'h04;
                    end
                    6'h04: begin mmode = 2; rdw = {1'b0, mem[pc], 1'b0}; expcmd = 6'h06; end
                    6'h06: begin pc++; expcmd = 6'h02; end
                    default: bad_order++;
                endcase
            end
        end else begin
            if (mmode == 1) msh[mbit] = sdata_out;
            mbit++;
            if (mbit == 16) begin
                if (mmode == 1) begin
                    if (msh[0] || msh[15]) bad_frame++;
                    latch = msh[14:1];
                end
                mbit = 0;
                mmode = 0;
                last_prog = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        for (int i = 0; i < 60000 && !done; i++) @(negedge clk);
        chk(done, "R8 run ended (watchdog)", done, 1);
    endtask

    task automatic run(input int n, input int inj, input bit poke);
        model_clear();
        inj_addr = inj;
        inj_bit = (inj < 0) ? 0 : (inj * 5) % 14;
        count = (AW+1)'(n);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            count = (AW+1)'(2);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        finish_run();
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        chk(!sclk && !sdata_out && sdata_oe && !done && !error, "R1 reset state",
            {sclk, sdata_out, sdata_oe, done, error}, 5'b00100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: zero count
        run(0, -1, 0);
        chk(done && !error, "R10 zero count done", {done, error}, 2'b10);
        chk(rises == 0, "R10 no clock pulses", rises, 0);

        // clean sweep over counts
        for (int n = 1; n <= 8; n++) begin
            seed = n;
            run(n, -1, (n == 5));
            chk(done && !error, "R8 clean run", {done, error}, 2'b10);
            chk(nprog == n, (n == 5) ? "R11 count latched" : "R4 words programmed", nprog, n);
            chk(pc == n - 1, "R4 no increment after last", pc, n - 1);
            chk(bad_order == 0, "R2 R4 command codes and order", bad_order, 0);
            chk(bad_frame == 0, "R3 start/stop bits", bad_frame, 0);
            chk(bad_gap == 0, "R5 inter-frame gap", bad_gap, 0);
            chk(bad_pw == 0, "R6 programming wait", bad_pw, 0);
            chk(bad_oe == 0, "R7 line direction", bad_oe, 0);
            for (int a = 0; a < n; a++)
                chk(mem[a] == img_f(a, seed), "R12 image word stored", mem[a], img_f(a, seed));
            begin
                int r0;
                r0 = rises;
                repeat (40) @(negedge clk);
                chk(rises == r0 && done, "R8 quiet after done", rises, r0);
            end
        end

        // injected faults, one per address
        seed = 77;
        for (int k = 0; k < 6; k++) begin
            int r0;
            run(6, k, 0);
            chk(done && error, "R9 failure flagged", {done, error}, 2'b11);
            chk(int'(err_addr) == k, "R9 failing index", err_addr, k);
            chk(nprog == k + 1, "R9 stop after failing word", nprog, k + 1);
            chk(bad_oe == 0, "R7 line direction in failing run", bad_oe, 0);
            r0 = rises;
            repeat (60) @(negedge clk);
            chk(rises == r0, "R9 no frames after failure", rises, r0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc == 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule